// File: doc/BRIEF.md
# Packed String Compare and Aggregate Core

This block compares two 128-bit operands, A and B, as packed strings. It treats each operand as sixteen bytes or eight 16-bit words. Every element of A is compared with every element of B. The result is a boolean matrix indexed by B element j and A element i.

The block works out a valid length for each operand. In explicit mode it takes the length from a signed 64-bit input. In implicit mode it takes it from the first zero element. Matrix entries that lie past either length are overridden by rules that depend on the aggregation mode. The matrix is then reduced to one bit per B element. Four reductions are offered: equal-any, range-pair, element-wise equality and ordered substring. A polarity control can invert the reduced word before it leaves the block.

The unit takes an operation on a cycle where `in_valid` is high and registers the results one clock later. A two-state machine runs the output side:

- ST_IDLE moves to ST_VALID when `in_valid` is high, and stays in ST_IDLE otherwise.
- ST_VALID stays in ST_VALID while `in_valid` is high, and returns to ST_IDLE when it is low.
- `out_valid` is high exactly in ST_VALID.

Control byte encoding:

| Bits | Meaning |
|------|---------|
| [0] | Element size: 1 gives 8 words, 0 gives 16 bytes |
| [1] | 1 selects signed comparison |
| [3:2] | Aggregation mode (see R5 to R8) |
| [5:4] | Polarity (see R9 and R10) |
| [7:6] | Ignored |

Top module: `pstr_cmp_core`

## Requirements
- R1: `ctrl[0]`=1 selects 8 word elements and `ctrl[0]`=0 selects 16 byte elements. Byte k of an operand is bits [8k+7:8k] and word k is bits [16k+15:16k]. In word mode, `res[15:8]` is zero.
- R2: `ctrl[1]`=1 compares elements as two's-complement signed values. `ctrl[1]`=0 compares them as unsigned values.
- R3: With `explicit_len`=1, each length is the absolute value of its signed input. The length is the element count (8 or 16) when the input is greater than the count or less than minus the count.
- R4: With `explicit_len`=0, each length is the index of the operand's first all-zero element. It is the element count when no element is zero.
- R5: `ctrl[3:2]`=0 selects equal-any. Bit j is set when some valid A[i] equals B[j] and B[j] is valid. An element is valid when its index is below its operand's length.
- R6: `ctrl[3:2]`=1 selects ranges. The entry is A[i]<=B[j] for even i and A[i]>=B[j] for odd i. Bit j is set when, for some even i, the entries for i and i+1 are both true. An entry is false when either of its elements is invalid.
- R7: `ctrl[3:2]`=2 selects equal-each. Bit j is A[j]==B[j] when both elements are valid. It is 1 when both are invalid and 0 when exactly one is invalid.
- R8: `ctrl[3:2]`=3 selects equal-ordered. Bit j is set when, for every i with j+i below the element count, the entry (B[j+i], A[i]) is true. An invalid A element makes its entry true; otherwise an invalid B element makes it false.
- R9: Polarity `ctrl[5:4]` values 0 and 2 leave the result unchanged. Value 1 inverts all element bits (8 or 16).
- R10: Polarity value 3 inverts only the bits j below the B length.
- R11: `res`, `len_a`, `len_b` and `out_valid`=1 appear one clock after a cycle with `in_valid`=1. After a cycle with `in_valid`=0, `out_valid` is 0 and the result outputs keep their values.
- R12: While `rst_n` is low, `out_valid`, `res`, `len_a` and `len_b` are zero.
- R13: `ctrl[7:6]` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present on the inputs |
| op_a | input | 128 | Operand A |
| op_b | input | 128 | Operand B |
| ctrl | input | 8 | Control byte (format, mode, polarity) |
| explicit_len | input | 1 | 1 takes lengths from the length inputs; 0 uses the zero terminator |
| len_a_in | input | 64 | Signed length of A for explicit mode |
| len_b_in | input | 64 | Signed length of B for explicit mode |
| out_valid | output | 1 | Registered results are from the previous cycle's operation |
| res | output | 16 | Aggregated result after polarity |
| len_a | output | 5 | Computed length of A |
| len_b | output | 5 | Computed length of B |

## Verification
Every result of an operation is due exactly one clock after the rising edge that saw `in_valid` high. This applies to `res`, both lengths and `out_valid`. The bench drives each operation on a falling edge and waits for the next rising edge. It then samples 1 ns later, which is before the next drive, so each check sees exactly one registered update. The hold check changes the inputs with `in_valid` low and samples after the same single edge, so it observes that nothing was captured. The reset checks sample during reset and just after its release, before any operation has been captured.

// File: rtl/pstr_pkg.sv
package pstr_pkg;
    typedef enum logic [1:0] {
        AGG_ANY   = 2'd0,
        AGG_RANGE = 2'd1,
        AGG_EACH  = 2'd2,
        AGG_ORDER = 2'd3
    } agg_e;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_VALID = 1'b1
    } state_e;
endpackage

// File: rtl/pstr_len_unit.sv
module pstr_len_unit #(
    parameter int DATA_W = 128,
    parameter int LEN_W  = 64,
    parameter int CNT_W  = 5
) (
    input  logic                    explicit_len,
    input  logic                    word_mode,
    input  logic [DATA_W-1:0]       op,
    input  logic signed [LEN_W-1:0] sval,
    output logic [CNT_W-1:0]        len
);
    localparam int NB = DATA_W / 8;
    localparam int NW = DATA_W / 16;

    logic [NB-1:0] zb;
    logic [NW-1:0] zw;

    genvar gk;
    for (gk = 0; gk < NB; gk++) begin : g_zb
        assign zb[gk] = (op[8*gk +: 8] == 8'd0);
    end
    for (gk = 0; gk < NW; gk++) begin : g_zw
        assign zw[gk] = (op[16*gk +: 16] == 16'd0);
    end

    always_comb begin : calc
        logic [CNT_W-1:0]        cnt;
        logic signed [LEN_W-1:0] lim;
        logic signed [LEN_W-1:0] mag;
        logic                    found;
        cnt   = word_mode ? CNT_W'(NW) : CNT_W'(NB);
        lim   = $signed({{(LEN_W-CNT_W){1'b0}}, cnt});
        mag   = sval[LEN_W-1] ? -sval : sval;
        found = 1'b0;
        len   = cnt;
        if (explicit_len) begin
            if (sval > lim || sval < -lim) len = cnt;
            else                           len = CNT_W'(mag);
        end else if (word_mode) begin
            for (int k = 0; k < NW; k++) begin
                if (!found && zw[k]) begin
                    len   = CNT_W'(k);
                    found = 1'b1;
                end
            end
        end else begin
            for (int k = 0; k < NB; k++) begin
                if (!found && zb[k]) begin
                    len   = CNT_W'(k);
                    found = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pstr_cmp_matrix.sv
module pstr_cmp_matrix
    import pstr_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int CNT_W  = 5
) (
    input  logic [DATA_W-1:0]                         op_a,
    input  logic [DATA_W-1:0]                         op_b,
    input  logic                                      word_mode,
    input  logic                                      sgn,
    input  agg_e                                      agg,
    input  logic [CNT_W-1:0]                          la,
    input  logic [CNT_W-1:0]                          lb,
    output logic [(DATA_W/8)*(DATA_W/8)-1:0]          m
);
    localparam int NB = DATA_W / 8;
    localparam int NW = DATA_W / 16;

    genvar gj, gi;
    for (gj = 0; gj < NB; gj++) begin : g_row
        for (gi = 0; gi < NB; gi++) begin : g_col
            logic signed [8:0]  ea, eb;
            logic signed [16:0] wa, wb;
            logic eq, le, ge, raw, vi, vj;

            assign ea = {sgn & op_a[8*gi+7], op_a[8*gi +: 8]};
            assign eb = {sgn & op_b[8*gj+7], op_b[8*gj +: 8]};
            if (gi < NW && gj < NW) begin : g_w
                assign wa = {sgn & op_a[16*gi+15], op_a[16*gi +: 16]};
                assign wb = {sgn & op_b[16*gj+15], op_b[16*gj +: 16]};
            end else begin : g_nw
                assign wa = '0;
                assign wb = '0;
            end

            assign vi = (CNT_W'(gi) < la);
            assign vj = (CNT_W'(gj) < lb);

            always_comb begin
                if (word_mode) begin
                    eq = (wa == wb);
                    le = (wa <= wb);
                    ge = (wa >= wb);
                end else begin
                    eq = (ea == eb);
                    le = (ea <= eb);
                    ge = (ea >= eb);
                end
                raw = (agg == AGG_RANGE) ? (((gi % 2) == 0) ? le : ge) : eq;
                unique case (agg)
                    AGG_ANY, AGG_RANGE: m[gj*NB+gi] = vi & vj & raw;
                    AGG_EACH:           m[gj*NB+gi] = (!vi && !vj) ? 1'b1
                                                    : (vi ^ vj) ? 1'b0 : raw;
                    AGG_ORDER:          m[gj*NB+gi] = !vi ? 1'b1
                                                    : !vj ? 1'b0 : raw;
                endcase
            end
        end
    end
endmodule

// File: rtl/pstr_aggregate.sv
module pstr_aggregate
    import pstr_pkg::*;
#(
    parameter int NB    = 16,
    parameter int CNT_W = 5
) (
    input  logic [NB*NB-1:0]  m,
    input  logic              word_mode,
    input  agg_e              agg,
    input  logic [1:0]        pol,
    input  logic [CNT_W-1:0]  lb,
    output logic [NB-1:0]     res
);
    localparam int NW = NB / 2;

    logic [NB-1:0] raw;
    logic [NB-1:0] all_mask;
    logic [NB-1:0] lb_mask;

    always_comb begin : reduce
        int   n;
        logic r;
        n = word_mode ? NW : NB;
        for (int j = 0; j < NB; j++) begin
            r = 1'b0;
            if (j < n) begin
                unique case (agg)
                    AGG_ANY: begin
                        for (int i = 0; i < NB; i++)
                            if (i < n && m[j*NB+i]) r = 1'b1;
                    end
                    AGG_RANGE: begin
                        for (int i = 0; i < NB; i += 2)
                            if (i < n && m[j*NB+i] && m[j*NB+i+1]) r = 1'b1;
                    end
                    AGG_EACH: r = m[j*NB+j];
                    AGG_ORDER: begin
                        r = 1'b1;
                        for (int i = 0; i < NB; i++)
                            if ((j + i) < n && !m[((j+i) % NB)*NB+i]) r = 1'b0;
                    end
                endcase
            end
            raw[j]      = r;
            all_mask[j] = (j < n);
            lb_mask[j]  = (j < int'(lb));
        end
    end

    always_comb begin
        unique case (pol)
            2'd1:    res = raw ^ all_mask;
            2'd3:    res = raw ^ lb_mask;
            default: res = raw;
        endcase
    end
endmodule

// File: rtl/pstr_cmp_core.sv
module pstr_cmp_core
    import pstr_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int LEN_W  = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [DATA_W-1:0]        op_a,
    input  logic [DATA_W-1:0]        op_b,
    input  logic [7:0]               ctrl,
    input  logic                     explicit_len,
    input  logic [LEN_W-1:0]         len_a_in,
    input  logic [LEN_W-1:0]         len_b_in,
    output logic                     out_valid,
    output logic [DATA_W/8-1:0]      res,
    output logic [$clog2(DATA_W/8+1)-1:0] len_a,
    output logic [$clog2(DATA_W/8+1)-1:0] len_b
);
    localparam int NB    = DATA_W / 8;
    localparam int NW    = DATA_W / 16;
    localparam int CNT_W = $clog2(NB + 1);

    logic             word_mode, sgn;
    agg_e             agg;
    logic [1:0]       pol;
    logic             unused_ctrl_hi;
    logic [CNT_W-1:0] la_c, lb_c;
    logic [NB*NB-1:0] mat;
    logic [NB-1:0]    res_c;
    logic [5:0]       ctrl_q;
    state_e           state_q, state_d;

    assign word_mode      = ctrl[0];
    assign sgn            = ctrl[1];
    assign agg            = agg_e'(ctrl[3:2]);
    assign pol            = ctrl[5:4];
    assign unused_ctrl_hi = ^ctrl[7:6];

    pstr_len_unit #(.DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_len_a (
        .explicit_len(explicit_len), .word_mode(word_mode), .op(op_a),
        .sval($signed(len_a_in)), .len(la_c));

    pstr_len_unit #(.DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_len_b (
        .explicit_len(explicit_len), .word_mode(word_mode), .op(op_b),
        .sval($signed(len_b_in)), .len(lb_c));

    pstr_cmp_matrix #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_mat (
        .op_a(op_a), .op_b(op_b), .word_mode(word_mode), .sgn(sgn),
        .agg(agg), .la(la_c), .lb(lb_c), .m(mat));

    pstr_aggregate #(.NB(NB), .CNT_W(CNT_W)) u_agg (
        .m(mat), .word_mode(word_mode), .agg(agg), .pol(pol),
        .lb(lb_c), .res(res_c));

    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = in_valid ? ST_VALID : ST_IDLE;
            ST_VALID: state_d = in_valid ? ST_VALID : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res    <= '0;
            len_a  <= '0;
            len_b  <= '0;
            ctrl_q <= '0;
        end else if (in_valid) begin
            res    <= res_c;
            len_a  <= la_c;
            len_b  <= lb_c;
            ctrl_q <= ctrl[5:0];
        end
    end

    assign out_valid = (state_q == ST_VALID);

    // R1: upper result half is clear for word elements
    p_word_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && ctrl_q[0] |-> res[NB-1:NW] == '0);

    // R3: computed lengths never exceed the element count
    p_len_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (len_a <= (ctrl_q[0] ? CNT_W'(NW) : CNT_W'(NB)))
                   && (len_b <= (ctrl_q[0] ? CNT_W'(NW) : CNT_W'(NB))));

    // R5: equal-any and ranges leave bits at or beyond the B length clear
    p_pad_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !ctrl_q[3] && ctrl_q[5:4] != 2'd1 |-> (res >> len_b) == '0);

    // R11: a captured operation shows as valid on the next cycle
    p_valid_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R11: without an operation the outputs hold and valid drops
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(res) && $stable(len_a) && $stable(len_b));
endmodule

// File: tb/test_pstr_cmp_core.sv
module test_pstr_cmp_core;
    typedef struct packed {
        logic [63:0]  tag;
        logic [127:0] a;
        logic [127:0] b;
        logic [7:0]   c;
        logic         e;
        logic [63:0]  la;
        logic [63:0]  lb;
        logic [15:0]  r;
        logic [4:0]   ea;
        logic [4:0]   eb;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        // equal-any, implicit bytes
        '{"R4 R5", 128'h0000000000000000_00000000_00636261, 128'h0000000000000000_0000007A_61796278,
          8'h00, 1'b0, 64'd0, 64'd0, 16'h000A, 5'd3, 5'd5},
        // ranges, unsigned bytes
        '{"R6", 128'h7A61, 128'h6F6C6C6548,
          8'h04, 1'b0, 64'd0, 64'd0, 16'h001E, 5'd2, 5'd5},
        // equal-each with explicit lengths
        '{"R7 R3", 128'h0F0E0D0C0B0A09080706050403020100, 128'h0F0E0D0C0B0A09080706050403FF0100,
          8'h08, 1'b1, 64'd6, 64'd4, 16'hFFCB, 5'd6, 5'd4},
        // equal-ordered, bytes
        '{"R8", 128'h6261, 128'h6261626178,
          8'h0C, 1'b0, 64'd0, 64'd0, 16'h000A, 5'd2, 5'd5},
        // words, equal-any, invert all, negative length
        '{"R1 R9", 128'h56781234, 128'h9999123400015678,
          8'h11, 1'b1, 64'd2, 64'hFFFFFFFFFFFFFFFD, 16'h00FA, 5'd2, 5'd3},
        // signed bytes ranges
        '{"R2 R6", 128'h10F0, 128'hF57F8000,
          8'h06, 1'b1, 64'd2, 64'd4, 16'h0009, 5'd2, 5'd4},
        // same, polarity 3
        '{"R10", 128'h10F0, 128'hF57F8000,
          8'h36, 1'b1, 64'd2, 64'd4, 16'h0006, 5'd2, 5'd4},
        // signed words equal-each, saturated lengths
        '{"R3 R1", 128'h7777666655554444333322221111_0000, 128'h77776666AAAA4444333322221111_0000,
          8'h0B, 1'b1, 64'd100, 64'hFFFFFFFFFFFFFFF7, 16'h00DF, 5'd8, 5'd8},
        // words equal-ordered, B has no zero, tail bit
        '{"R8 R4", 128'h00020001, 128'h0001000900020001000700020001_0005,
          8'h0D, 1'b0, 64'd0, 64'd0, 16'h0092, 5'd2, 5'd8},
        // no zero bytes, polarity 2
        '{"R4 R9", 128'h41414141414141414141414141414141, 128'h41424242424242424242424242424242,
          8'h20, 1'b0, 64'd0, 64'd0, 16'h8000, 5'd16, 5'd16},
        // zero lengths, equal-each, polarity 3
        '{"R7 R10", 128'h1, 128'h2,
          8'h38, 1'b1, 64'd0, 64'd0, 16'hFFFF, 5'd0, 5'd0},
        // length at the limit and one beyond, invert all
        '{"R3 R9", 128'h0F0E0D0C0B0A09080706050403020100, 128'h0F0E0D0C0B0A09080706050403020100,
          8'h10, 1'b1, 64'd16, 64'hFFFFFFFFFFFFFFEF, 16'h0000, 5'd16, 5'd16}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] op_a = '0, op_b = '0;
    logic [7:0]   ctrl = '0;
    logic         explicit_len = 1'b0;
    logic [63:0]  len_a_in = '0, len_b_in = '0;
    logic         out_valid;
    logic [15:0]  res;
    logic [4:0]   len_a, len_b;
    int           n_checks = 0;
    int           n_errors = 0;

    always #2 clk = ~clk;

    pstr_cmp_core i_pstr_cmp_core (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .ctrl(ctrl), .explicit_len(explicit_len), .len_a_in(len_a_in),
        .len_b_in(len_b_in), .out_valid(out_valid), .res(res),
        .len_a(len_a), .len_b(len_b));

    task automatic check(input string what, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic valid);
        @(negedge clk);
        op_a = v.a; op_b = v.b; ctrl = v.c; explicit_len = v.e;
        len_a_in = v.la; len_b_in = v.lb; in_valid = valid;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 4);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        vec_t tmp;
        repeat (3) @(posedge clk);
        #1;
        check("R12 out_valid in reset", {15'd0, out_valid}, 16'd0);
        check("R12 res in reset", res, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R12 lengths after release", {6'd0, len_a, len_b}, 16'd0);

        for (int k = 0; k < NV; k++) begin
            drive(VECS[k], 1'b1);
            check($sformatf("%s vec %0d res", VECS[k].tag, k), res, VECS[k].r);
            check($sformatf("%s vec %0d len_a", VECS[k].tag, k), {11'd0, len_a}, {11'd0, VECS[k].ea});
            check($sformatf("%s vec %0d len_b", VECS[k].tag, k), {11'd0, len_b}, {11'd0, VECS[k].eb});
            check($sformatf("R11 vec %0d out_valid", k), {15'd0, out_valid}, 16'd1);
        end

        // R11: inputs change with in_valid low; outputs hold, valid drops
        drive(VECS[0], 1'b0);
        check("R11 hold res", res, VECS[NV-1].r);
        check("R11 hold len_a", {11'd0, len_a}, {11'd0, VECS[NV-1].ea});
        check("R11 out_valid low", {15'd0, out_valid}, 16'd0);

        // R13: upper control bits ignored
        tmp = VECS[0];
        tmp.c = 8'hC0;
        drive(tmp, 1'b1);
        check("R13 ctrl[7:6] set res", res, 16'h000A);
        check("R13 ctrl[7:6] set len_b", {11'd0, len_b}, 16'd5);
        tmp = VECS[5];
        tmp.c = 8'hC6;
        drive(tmp, 1'b1);
        check("R13 ranges with ctrl[7:6] set", res, 16'h0009);

        // R2: same data unsigned gives no range hit
        tmp = VECS[5];
        tmp.c = 8'h04;
        drive(tmp, 1'b1);
        check("R2 unsigned ranges", res, 16'h0000);

        // R12: reset during operation clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R12 mid-run reset res", res, 16'd0);
        check("R12 mid-run reset valid", {15'd0, out_valid}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule